// File: doc/BRIEF.md
# Half-Duplex Line Direction Controller

This block drives the direction pin of a half-duplex differential transceiver that sits behind a UART transmitter. The pin turns the transceiver toward the line as soon as the transmitter reports that it has a character waiting. After the final stop bit has gone out, the pin keeps the line for a programmable turnaround time, measured in whole bit periods. When that time has elapsed, the pin hands the line back so that other nodes can drive it.

The turnaround value is 8 bits wide and covers 0 to 255 bit times. The surrounding transmitter supplies three inputs: a level that says data is pending, a single-cycle strobe when the last stop bit completes, and a one-cycle tick for each bit period. A polarity control chooses whether the pin is active-low or active-high. Inside, a three-state controller (idle, transmitting, holding) works with a down-counter that only advances on bit ticks while holding.

Top module: `dirctl_top`

## Requirements
- R1: Out of reset, and for as long as the controller stays idle, `dir_out` sits at its inactive level for the present `pol_invert` value: 1 when `pol_invert`=0, 0 when `pol_invert`=1. It follows any change of `pol_invert` in the same cycle.
- R2: If `tx_pending` is 1 at a rising clock edge, `dir_out` is at its active level from that edge onward.
- R3: The active level is 0 when `pol_invert`=0 and 1 when `pol_invert`=1.
- R4: When `stop_done` is 1 and `tx_pending` is 0 at an edge, with `turn_delay`=D>0, `dir_out` stays active through the next D-1 `bit_tick` pulses. It goes inactive at the edge that samples the D-th tick. A tick that arrives in the same cycle as the strobe is not counted.
- R5: With `turn_delay`=0, `dir_out` goes inactive at the edge that samples `stop_done`.
- R6: If `tx_pending` rises during the hold period, the countdown is cancelled and `dir_out` stays active. The next `stop_done` starts a full new delay.
- R7: The delay is captured at the `stop_done` edge. Changes to `turn_delay` during the hold period have no effect on its length.
- R8: A `stop_done` or `bit_tick` seen while idle leaves `dir_out` inactive. A `bit_tick` seen while transmitting leaves `dir_out` active.
- R9: A `stop_done` that coincides with `tx_pending`=1 starts no hold: `dir_out` stays active, whatever ticks follow.
- R10: The largest delay, 255, holds the line for exactly 255 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_pending | input | 1 | Transmitter has a character waiting or in flight |
| stop_done | input | 1 | One-cycle strobe: last stop bit has left the shifter |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| turn_delay | input | DLY_W (8) | Turnaround delay in bit times |
| pol_invert | input | 1 | 0: active-low pin, 1: active-high pin |
| dir_out | output | 1 | Transceiver direction pin |

## Verification
Each stimulus acts on `dir_out` through exactly one register, the state flop. An input change made at a falling edge therefore shows on the pin after the next rising edge, and `pol_invert` acts on the pin combinationally with no delay at all. The bench drives inputs at falling edges and samples one falling edge later, so every check falls on the single cycle in which the new value is due. For the hold period, the bench counts ticks itself and checks the pin after every tick and every gap cycle. The expected release comes at the sampled D-th tick, for every delay from 0 to 40 under both polarities, and for delay 255.

// File: rtl/dirctl_pkg.sv
package dirctl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_HOLD   = 2'd2
    } dir_state_e;

    typedef struct packed {
        dir_state_e state;
        logic       active;
    } fsm_reg_t;
endpackage

// File: rtl/dirctl_hold_cnt.sv
module dirctl_hold_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         cnt_one,
    output logic         cnt_zero
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_one  = (cnt_q == ONE);
    assign cnt_zero = (cnt_q == '0);

    // R7: the value captured at the strobe is what the counter holds next
    assert_load_captures_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

    // R4: each accepted tick removes exactly one bit time
    assert_dec_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> (cnt_q == $past(cnt_q) - ONE));

    // R4: the controller never asks to count below zero
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !cnt_zero);
endmodule

// File: rtl/dirctl_fsm.sv
module dirctl_fsm
    import dirctl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_pending,
    input  logic         stop_done,
    input  logic         bit_tick,
    input  logic [W-1:0] delay,
    input  logic         cnt_one,
    input  logic         cnt_zero,
    output logic         load,
    output logic         dec,
    output logic         active_o
);
    fsm_reg_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        load  = 1'b0;
        dec   = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (tx_pending) nxt_d.state = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (stop_done && !tx_pending) begin
                    if (delay == '0) begin
                        nxt_d.state = ST_IDLE;
                    end else begin
                        nxt_d.state = ST_HOLD;
                        load        = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (tx_pending) begin
                    nxt_d.state = ST_ACTIVE;
                end else if (bit_tick) begin
                    dec = 1'b1;
                    if (cnt_one) nxt_d.state = ST_IDLE;
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
        nxt_d.active = (nxt_d.state != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state  <= ST_IDLE;
            cur_q.active <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign active_o = cur_q.active;

    // R2: pending data always claims the line on the next cycle
    assert_pending_claims_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pending |=> cur_q.active);

    // R5: zero delay releases straight after the strobe
    assert_zero_delay_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_ACTIVE && stop_done && !tx_pending && delay == '0)
        |=> !cur_q.active);

    // R4: holding is only possible with bit times left to count
    assert_hold_has_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_HOLD) |-> !cnt_zero);

    // R8: idle without pending data stays idle
    assert_idle_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_IDLE && !tx_pending) |=> !cur_q.active);
endmodule

// File: rtl/dirctl_drive.sv
module dirctl_drive (
    input  logic active,
    input  logic invert,
    output logic dir_o
);
    always_comb begin
        if (invert) dir_o = active;
        else        dir_o = ~active;
    end
endmodule

// File: rtl/dirctl_top.sv
module dirctl_top #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_pending,
    input  logic             stop_done,
    input  logic             bit_tick,
    input  logic [DLY_W-1:0] turn_delay,
    input  logic             pol_invert,
    output logic             dir_out
);
    logic load, dec, cnt_one, cnt_zero, active;

    dirctl_fsm #(.W(DLY_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_pending (tx_pending),
        .stop_done  (stop_done),
        .bit_tick   (bit_tick),
        .delay      (turn_delay),
        .cnt_one    (cnt_one),
        .cnt_zero   (cnt_zero),
        .load       (load),
        .dec        (dec),
        .active_o   (active)
    );

    dirctl_hold_cnt #(.W(DLY_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (turn_delay),
        .dec      (dec),
        .cnt_one  (cnt_one),
        .cnt_zero (cnt_zero)
    );

    dirctl_drive u_drv (
        .active (active),
        .invert (pol_invert),
        .dir_o  (dir_out)
    );
endmodule

// File: tb/sim_dirctl_top.sv
module sim_dirctl_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_pending = 1'b0;
    logic       stop_done = 1'b0;
    logic       bit_tick = 1'b0;
    logic [7:0] turn_delay = 8'd0;
    logic       pol_invert = 1'b0;
    logic       dir_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    dirctl_top u0 (.*);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic lvl(input logic act, input logic inv);
        return inv ? act : ~act;
    endfunction

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input logic act, input string req);
        logic exp;
        exp = lvl(act, pol_invert);
        checks = checks + 1;
        if (dir_out !== exp) begin
            failures = failures + 1;
            $display("FAIL %s got=%b exp=%b t=%0t", req, dir_out, exp, $time);
        end
    endtask

    // Claim the line, then send the final stop bit with no more data
    task automatic claim_and_stop(input logic [7:0] d);
        turn_delay = d;
        tx_pending = 1'b1;
        cyc();
        chk(1'b1, "R2");
        chk(1'b1, "R3");
        cyc();
        stop_done  = 1'b1;
        tx_pending = 1'b0;
        cyc();
        stop_done  = 1'b0;
    endtask

    task automatic hold_ticks(input int n, input int gap, input logic last_releases, input string req);
        for (int k = 1; k <= n; k++) begin
            for (int g = 1; g < gap; g++) begin
                cyc();
                chk(1'b1, req);
            end
            bit_tick = 1'b1;
            cyc();
            bit_tick = 1'b0;
            chk(!(last_releases && k == n), req);
        end
    endtask

    task automatic run_delay(input logic [7:0] d, input int gap, input string req);
        claim_and_stop(d);
        if (d == 8'd0) chk(1'b0, "R5");
        else begin
            chk(1'b1, req);
            hold_ticks(int'(d), gap, 1'b1, req);
        end
        cyc();
        chk(1'b0, req);
    endtask

    initial begin
        // R1: reset level follows polarity
        cyc();
        chk(1'b0, "R1");
        pol_invert = 1'b1;
        #1;
        chk(1'b0, "R1");
        pol_invert = 1'b0;
        cyc();
        rst_n = 1'b1;
        cyc();
        chk(1'b0, "R1");

        // R8: idle ignores strobes and ticks
        stop_done = 1'b1;
        bit_tick  = 1'b1;
        cyc();
        stop_done = 1'b0;
        cyc();
        bit_tick = 1'b0;
        chk(1'b0, "R8");

        // R4/R5/R3 sweep over delays and both polarities
        for (int inv = 0; inv < 2; inv++) begin
            pol_invert = inv[0];
            for (int d = 0; d <= 40; d++) begin
                run_delay(8'(d), 1 + (d % 3), "R4");
            end
        end
        pol_invert = 1'b0;

        // R10: maximum delay
        run_delay(8'd255, 1, "R10");

        // R8: ticks while transmitting are ignored
        tx_pending = 1'b1;
        bit_tick   = 1'b1;
        for (int i = 0; i < 10; i++) begin
            cyc();
            chk(1'b1, "R8");
        end
        bit_tick = 1'b0;

        // R9: stop with data still pending starts no hold
        turn_delay = 8'd2;
        stop_done  = 1'b1;
        cyc();
        stop_done  = 1'b0;
        chk(1'b1, "R9");
        tx_pending = 1'b0;
        bit_tick   = 1'b1;
        for (int i = 0; i < 6; i++) begin
            cyc();
            chk(1'b1, "R9");
        end
        bit_tick = 1'b0;
        // the transmitter never strobed a final stop, so still active
        stop_done = 1'b1;
        turn_delay = 8'd0;
        cyc();
        stop_done = 1'b0;
        chk(1'b0, "R5");

        // R6: new data cancels the hold, next stop restarts a full delay
        pol_invert = 1'b1;
        claim_and_stop(8'd5);
        hold_ticks(2, 2, 1'b0, "R6");
        tx_pending = 1'b1;
        bit_tick   = 1'b1;
        for (int i = 0; i < 6; i++) begin
            cyc();
            chk(1'b1, "R6");
        end
        bit_tick   = 1'b0;
        stop_done  = 1'b1;
        tx_pending = 1'b0;
        cyc();
        stop_done  = 1'b0;
        chk(1'b1, "R6");
        hold_ticks(5, 1, 1'b1, "R6");

        // R7: delay change during hold has no effect
        pol_invert = 1'b0;
        claim_and_stop(8'd3);
        turn_delay = 8'd200;
        hold_ticks(3, 2, 1'b1, "R7");
        cyc();
        chk(1'b0, "R7");

        // R4: a tick coinciding with the strobe is not counted
        turn_delay = 8'd2;
        tx_pending = 1'b1;
        cyc();
        stop_done  = 1'b1;
        bit_tick   = 1'b1;
        tx_pending = 1'b0;
        cyc();
        stop_done  = 1'b0;
        bit_tick   = 1'b0;
        chk(1'b1, "R4");
        hold_ticks(2, 2, 1'b1, "R4");

        // R1: idle level follows polarity live
        pol_invert = 1'b1;
        #1;
        chk(1'b0, "R1");
        pol_invert = 1'b0;
        #1;
        chk(1'b0, "R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule